// File: doc/BRIEF.md
# Time-Code Pulse-Width Bit Decoder

This block turns the demodulated output of a long-wave time-code receiver into a byte stream. The receiver line rests high and drops low once per second. A short low pulse carries a 0 and a long one carries a 1. The block measures each low pulse in milliseconds, counted from a free-running tick, against a mid-point threshold. When the pulse ends, it emits the decoded bit as a byte on a valid/ready interface.

One second in each minute carries no pulse. The block detects that silence from the time elapsed since the previous decoded bit. In that case it inserts a start-of-minute byte ahead of the next data byte and restarts its bit index. A downstream consumer, such as a serial transmitter, can therefore frame minutes without timing the line itself.

Top module: `tcode_pulse_decoder`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `bit_index` is 0 and `overflow` is 0. The line is taken as resting high.
- R2: A low pulse that ends before THRESH_MS (default 150) millisecond ticks have elapsed since its falling edge decodes as a 0, emitted as the byte 0x00.
- R3: A low pulse still low after THRESH_MS ticks decodes as a 1, emitted as the byte 0x01.
- R4: A byte is produced only by the rising edge that ends a low pulse. No byte appears while the line is low.
- R5: The block counts milliseconds since the last decoded bit, or since reset. The count restarts on every decoded bit and saturates. If it exceeds GAP_MS (default 1700) when a bit is decoded, the marker byte 0x02 is queued ahead of that bit's data byte.
- R6: `bit_index` increases by one on every qualified falling edge and saturates at its maximum. It is cleared to 0 by a decoded bit that carries the marker.
- R7: A pending byte holds `out_data` and `out_valid` stable until `out_ready` is high. When the marker and the data byte are both pending, the marker is presented first.
- R8: A bit decoded while any byte is still pending is dropped. `overflow` then rises and stays at 1 until reset.
- R9: An input level equal to the recorded previous level causes no action. While the line stays high, no byte is produced and `bit_index` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous demodulated receiver line, idle high |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| out_data | output | 8 | Byte presented: 0x00, 0x01 or marker 0x02 |
| out_valid | output | 1 | A byte is pending on `out_data` |
| out_ready | input | 1 | Consumer accepts the byte in this cycle |
| bit_index | output | 6 | Position of the current bit within the minute |
| overflow | output | 1 | Sticky flag: a decoded bit was dropped |

## Verification
A stuck or miscounted threshold timer shows up as a wrong data byte on the very next rising edge, a few cycles after the pulse ends. A fault in the gap timer shows up as a missing or spurious 0x02 byte on the first bit after a long idle stretch. A fault in the bit index is visible on `bit_index` one cycle after the falling edge that should move it. The bench reads each of these at the port within about twenty cycles of the edge that causes it. It does this over a sequence that mixes short and long pulses, values near the threshold and silent seconds. It also stalls the consumer to show that held bytes stay put and that a dropped bit sets the flag.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    // Byte inserted ahead of the first bit of a new minute.
    localparam logic [7:0] MARK_BYTE = 8'h02;

    // One decoded bit event from the classifier.
    typedef struct packed {
        logic valid;
        logic value;
    } tpd_bit_t;

endpackage

// File: rtl/tpd_sync.sv
module tpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    // Reset to the idle (high) level so no false edge follows reset.
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tpd_classifier.sv
module tpd_classifier
    import tpd_pkg::*;
#(
    parameter int THRESH_MS = 150,
    localparam int TW = $clog2(THRESH_MS + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_s,
    input  logic     ms_tick,
    output logic     fall_evt,
    output tpd_bit_t bit_o
);
    localparam logic [TW-1:0] LAST_TICK = TW'(THRESH_MS - 1);

    typedef struct packed {
        logic          prev;
        logic          busy;
        logic [TW-1:0] cnt;
        tpd_bit_t      bit_ev;
    } cls_t;

    cls_t s_d, s_q;
    logic fall, rise;

    always_comb begin
        s_d = s_q;
        s_d.bit_ev.valid = 1'b0;
        fall = s_q.prev & ~line_s;
        rise = ~s_q.prev & line_s;

        if (s_q.busy && ms_tick) begin
            if (s_q.cnt == LAST_TICK) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + TW'(1);
            end
        end

        if (fall) begin
            s_d.prev = 1'b0;
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end

        if (rise) begin
            s_d.prev         = 1'b1;
            s_d.busy         = 1'b0;
            s_d.cnt          = '0;
            s_d.bit_ev.valid = 1'b1;
            s_d.bit_ev.value = ~s_q.busy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fall_evt = fall;
    assign bit_o    = s_q.bit_ev;

    // A decoded bit follows a recorded return to high.
    p_bit_needs_high_r4: assert property (@(posedge clk) disable iff (rst)
        s_q.bit_ev.valid |-> s_q.prev);

    // The timer never runs while the line is recorded high.
    p_timer_only_low_r3: assert property (@(posedge clk) disable iff (rst)
        s_q.busy |-> !s_q.prev);
endmodule

// File: rtl/tpd_gap_timer.sv
module tpd_gap_timer #(
    parameter int GAP_MS = 1700,
    localparam int GW = $clog2(GAP_MS + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic restart,
    output logic gap_long
);
    localparam logic [GW-1:0] CNT_MAX = '1;
    localparam logic [GW-1:0] GAP_LIM = GW'(GAP_MS);

    typedef struct packed {
        logic [GW-1:0] cnt;
    } gap_t;

    gap_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (ms_tick && s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign gap_long = (s_q.cnt > GAP_LIM);

    p_gap_restart_r5: assert property (@(posedge clk) disable iff (rst)
        restart |=> s_q.cnt == '0);

    p_gap_saturate_r5: assert property (@(posedge clk) disable iff (rst)
        (s_q.cnt == CNT_MAX) |=> (s_q.cnt == CNT_MAX) || $past(restart));
endmodule

// File: rtl/tpd_byte_slot.sv
module tpd_byte_slot
    import tpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tpd_bit_t   bit_i,
    input  logic       gap_long,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       overflow
);
    typedef struct packed {
        logic mark_pend;
        logic data_pend;
        logic data_bit;
        logic ovf;
    } slot_t;

    slot_t s_d, s_q;
    logic  busy;

    always_comb begin
        s_d  = s_q;
        busy = s_q.mark_pend | s_q.data_pend;

        if (busy && out_ready) begin
            if (s_q.mark_pend) s_d.mark_pend = 1'b0;
            else               s_d.data_pend = 1'b0;
        end

        if (bit_i.valid) begin
            if (busy) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.mark_pend = gap_long;
                s_d.data_pend = 1'b1;
                s_d.data_bit  = bit_i.value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = s_q.mark_pend | s_q.data_pend;
    assign out_data  = s_q.mark_pend ? MARK_BYTE : {7'b0, s_q.data_bit};
    assign overflow  = s_q.ovf;

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    p_marker_before_data_r7: assert property (@(posedge clk) disable iff (rst)
        s_q.mark_pend |-> s_q.data_pend);

    p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (rst)
        s_q.ovf |=> s_q.ovf);

    p_bit_byte_range_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !s_q.mark_pend) |-> out_data[7:1] == 7'b0);
endmodule

// File: rtl/tcode_pulse_decoder.sv
module tcode_pulse_decoder
    import tpd_pkg::*;
#(
    parameter int THRESH_MS   = 150,
    parameter int GAP_MS      = 1700,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic             ms_tick,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] bit_index,
    output logic             overflow
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic     line_s;
    logic     fall_evt;
    logic     gap_long;
    logic     idx_clr;
    tpd_bit_t bit_ev;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } top_t;

    top_t s_d, s_q;

    tpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    tpd_classifier #(.THRESH_MS(THRESH_MS)) u_cls (
        .clk      (clk),
        .rst      (rst),
        .line_s   (line_s),
        .ms_tick  (ms_tick),
        .fall_evt (fall_evt),
        .bit_o    (bit_ev)
    );

    tpd_gap_timer #(.GAP_MS(GAP_MS)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .ms_tick  (ms_tick),
        .restart  (bit_ev.valid),
        .gap_long (gap_long)
    );

    tpd_byte_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .bit_i     (bit_ev),
        .gap_long  (gap_long),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .overflow  (overflow)
    );

    // A marker-carrying bit starts a new minute; clearing wins over a step.
    always_comb begin
        s_d     = s_q;
        idx_clr = bit_ev.valid & gap_long;
        if (idx_clr) begin
            s_d.idx = '0;
        end else if (fall_evt && s_q.idx != IDX_MAX) begin
            s_d.idx = s_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign bit_index = s_q.idx;

    p_index_step_r6: assert property (@(posedge clk) disable iff (rst)
        (fall_evt && !idx_clr && s_q.idx != IDX_MAX)
            |=> s_q.idx == $past(s_q.idx) + IDX_W'(1));

    p_index_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_ev.valid && gap_long) |=> s_q.idx == '0);

    p_index_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!fall_evt && !bit_ev.valid) |=> $stable(s_q.idx));
endmodule

// File: tb/tb_tcode_pulse_decoder.sv
module tb_tcode_pulse_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       ms_tick = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [5:0] bit_index;
    logic       overflow;

    int checks = 0;
    int errors = 0;
    logic [7:0] rxq [0:255];
    int wr = 0;
    int rd = 0;

    tcode_pulse_decoder dut (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .ms_tick   (ms_tick),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .bit_index (bit_index),
        .overflow  (overflow)
    );

    always #4 clk = ~clk;

    // One millisecond = two clock cycles in this bench.
    always @(negedge clk) ms_tick <= ~ms_tick;

    // Record every accepted byte.
    always @(negedge clk) begin
        if (out_valid && out_ready) begin
            rxq[wr[7:0]] = out_data;
            wr = wr + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ms(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic expect_byte(input int exp, input string req);
        int guard = 0;
        while (rd >= wr && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        if (rd < wr) begin
            chk(rxq[rd[7:0]] == exp[7:0], req, "byte", rxq[rd[7:0]], exp);
            rd++;
        end else begin
            chk(1'b0, req, "byte missing", -1, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] low;
        logic [15:0] high;
        logic        mark;
        logic        val;
        logic [5:0]  idx;
    } vec_t;

    // low ms, following high ms, marker expected, bit, index after byte
    localparam vec_t VECS [8] = '{
        '{16'd100, 16'd900,  1'b0, 1'b0, 6'd1},
        '{16'd200, 16'd800,  1'b0, 1'b1, 6'd2},
        '{16'd140, 16'd860,  1'b0, 1'b0, 6'd3},
        '{16'd160, 16'd1840, 1'b0, 1'b1, 6'd4},
        '{16'd100, 16'd900,  1'b1, 1'b0, 6'd0},
        '{16'd200, 16'd800,  1'b0, 1'b1, 6'd1},
        '{16'd100, 16'd1900, 1'b0, 1'b0, 6'd2},
        '{16'd200, 16'd100,  1'b1, 1'b1, 6'd0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(bit_index == 6'd0, "R1", "bit_index after reset", bit_index, 0);
        chk(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
        rst = 1'b0;

        // R9: idle high line produces nothing
        wait_ms(50);
        chk(wr == 0, "R9", "bytes while idle", wr, 0);
        chk(bit_index == 6'd0, "R9", "index while idle", bit_index, 0);

        for (int i = 0; i < 8; i++) begin
            rx_line = 1'b0;
            wait_ms(int'(VECS[i].low));
            chk(wr == rd, "R4", "byte during low pulse", wr - rd, 0);
            rx_line = 1'b1;
            repeat (20) @(negedge clk);
            if (VECS[i].mark) expect_byte(8'h02, "R5");
            expect_byte({7'b0, VECS[i].val}, VECS[i].val ? "R3" : "R2");
            chk(bit_index == VECS[i].idx, "R6", "bit_index", bit_index,
                int'(VECS[i].idx));
            chk(wr == rd, "R5", "extra byte", wr - rd, 0);
            wait_ms(int'(VECS[i].high) - 10);
        end

        // R7: stalled consumer, marker held first
        out_ready = 1'b0;
        wait_ms(1900);
        rx_line = 1'b0;
        wait_ms(200);
        rx_line = 1'b1;
        repeat (20) @(negedge clk);
        chk(out_valid == 1'b1, "R7", "valid while stalled", out_valid, 1);
        chk(out_data == 8'h02, "R7", "marker presented first", out_data, 2);
        repeat (50) @(negedge clk);
        chk(out_data == 8'h02, "R7", "marker held", out_data, 2);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        expect_byte(8'h02, "R7");
        chk(out_valid == 1'b1 && out_data == 8'h01, "R7", "data after marker",
            out_data, 1);

        // R8: bit during stall is dropped, overflow sticks
        wait_ms(800);
        rx_line = 1'b0;
        wait_ms(100);
        rx_line = 1'b1;
        repeat (20) @(negedge clk);
        chk(overflow == 1'b1, "R8", "overflow set", overflow, 1);
        chk(out_data == 8'h01, "R8", "held byte unchanged", out_data, 1);
        out_ready = 1'b1;
        expect_byte(8'h01, "R8");
        repeat (10) @(negedge clk);
        chk(out_valid == 1'b0 && wr == rd, "R8", "dropped bit absent",
            wr - rd, 0);
        wait_ms(880);
        rx_line = 1'b0;
        wait_ms(100);
        rx_line = 1'b1;
        repeat (20) @(negedge clk);
        expect_byte(8'h00, "R2");
        chk(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);

        // R1: reset clears the sticky flag
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(overflow == 1'b0, "R1", "overflow after second reset", overflow, 0);
        chk(out_valid == 1'b0, "R1", "valid after second reset", out_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule